// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits on the byte stream between an HDLC receive deframer and the receive FIFO. For every frame it inspects the first two bytes of the address field, compares them against two configuration words, and decides whether the frame may be written into the FIFO. The byte stream itself is forwarded unchanged, in order and with its frame marks. The decision appears as a write enable that travels with every forwarded byte of the frame.

Each configuration word holds a compare pattern in its upper bits and an enable in bit 0. The first byte is compared over its six upper bits and the second byte over its seven upper bits. A second byte whose upper seven bits are all ones is a broadcast address and always matches. A global recognition enable switches filtering on and off. The configuration and the global enable are captured when the first byte of a frame arrives, so writes made during a frame do not affect that frame.

The first two bytes of a frame are held in a two-entry line until the second byte has been seen. A held entry leaves the line when a later byte pushes it out, or on its own once the frame's last byte is inside the line.

Top module: `hdlc_addr_filter`

## Requirements
- R1: Every input byte appears exactly once on the output, in arrival order, with its start-of-frame and end-of-frame marks unchanged.
- R2: When bit 0 of `addr1_cfg_i` is 1, the first byte matches only if its bits 7..2 equal `addr1_cfg_i[7:2]`. Bit 1 of the byte and bit 1 of the configuration word are ignored.
- R3: When bit 0 of `addr1_cfg_i` is 0, the first byte matches whatever its value.
- R4: When bit 0 of `addr2_cfg_i` is 1, the second byte matches if its bits 7..1 equal `addr2_cfg_i[7:1]`. Bit 0 of the byte is ignored. When bit 0 of the word is 0, the second byte always matches.
- R5: A second byte whose bits 7..1 are all ones (0xFE or 0xFF) matches regardless of `addr2_cfg_i[7:1]`.
- R6: When `recog_en_i` is 0 at the start of a frame, or both configuration enable bits are 0, the frame is accepted.
- R7: An accepted frame has `wr_en_o` = 1 on every one of its output bytes. A frame that fails an enabled comparison while recognition is on has `wr_en_o` = 0 on every byte.
- R8: A frame whose end-of-frame mark arrives on its first byte is discarded if recognition is on and at least one configuration enable is 1. Otherwise it is accepted.
- R9: The configuration words and `recog_en_i` are sampled on the start-of-frame byte. Changes made later in that frame have no effect on its decision.
- R10: At most two bytes are held inside the block, and they stay held while input is idle in mid-frame. Once the end-of-frame byte has entered, the held bytes leave on successive cycles, starting the cycle after that byte is captured.
- R11: While reset is asserted, `out_valid_o` and `wr_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_byte_i | input | 8 | Input byte |
| in_sof_i | input | 1 | Input byte is the first byte of a frame |
| in_eof_i | input | 1 | Input byte is the last byte of a frame |
| recog_en_i | input | 1 | Global address recognition enable |
| addr1_cfg_i | input | 8 | First-byte pattern in bits 7..2, compare enable in bit 0 |
| addr2_cfg_i | input | 8 | Second-byte pattern in bits 7..1, compare enable in bit 0 |
| out_valid_o | output | 1 | Output byte valid |
| out_byte_o | output | 8 | Output byte |
| out_sof_o | output | 1 | Output byte starts a frame |
| out_eof_o | output | 1 | Output byte ends a frame |
| wr_en_o | output | 1 | FIFO write enable for the output byte |

## Verification
The assertions assume a well-formed input stream. Every frame opens with a valid byte that carries the start mark and closes with one that carries the end mark, and no byte falls outside a frame. The per-frame uniformity check depends on this, because it treats each start mark as the first output of a new decision. The stimulus only sends complete frames through one task sequence that always sets the start mark on the first byte and the end mark on the last. Configuration changes are applied strictly after the start byte has been captured. Idle gaps are placed both inside frames and between them, and frames are also sent back to back, so the release-on-push and release-on-drain paths both stay inside these assumptions.

// File: rtl/hafp_pkg.sv
package hafp_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic              vld;
    logic              sof;
    logic              eof;
    logic              drop;   // single-byte frame verdict, fixed on entry
    logic [BYTE_W-1:0] data;
  } slot_t;
endpackage

// File: rtl/hafp_addr_cmp.sv
module hafp_addr_cmp
  import hafp_pkg::*;
#(
  parameter int unsigned CMP_BITS = 6,
  parameter bit          BCAST_EN = 1'b0
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [BYTE_W-1:0] cfg_i,
  output logic              match_o
);
  localparam int unsigned LSB = BYTE_W - CMP_BITS;

  logic eq, bcast;

  assign eq = (byte_i[BYTE_W-1:LSB] == cfg_i[BYTE_W-1:LSB]);

  generate
    if (BCAST_EN) begin : g_bcast
      assign bcast = &byte_i[BYTE_W-1:LSB];
    end else begin : g_no_bcast
      assign bcast = 1'b0;
    end
  endgenerate

  assign match_o = ~cfg_i[0] | eq | bcast;
endmodule

// File: rtl/hafp_hold_line.sv
module hafp_hold_line
  import hafp_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  shift_i,
  input  slot_t slot_i,
  output slot_t tail_o,
  output logic  eof_held_o
);
  slot_t q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q[0] <= '0;
    else if (shift_i) q[0] <= slot_i;
  end

  generate
    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      q[i] <= '0;
        else if (shift_i) q[i] <= q[i-1];
      end
    end
  endgenerate

  always_comb begin
    eof_held_o = 1'b0;
    for (int i = 0; i < DEPTH; i++) eof_held_o = eof_held_o | (q[i].vld & q[i].eof);
  end

  assign tail_o = q[DEPTH-1];
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
  import hafp_pkg::*;
#(
  parameter int unsigned A1_BITS = 6,
  parameter int unsigned A2_BITS = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_byte_i,
  input  logic              in_sof_i,
  input  logic              in_eof_i,
  input  logic              recog_en_i,
  input  logic [BYTE_W-1:0] addr1_cfg_i,
  input  logic [BYTE_W-1:0] addr2_cfg_i,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_byte_o,
  output logic              out_sof_o,
  output logic              out_eof_o,
  output logic              wr_en_o
);
  localparam int unsigned HOLD = 2;  // two address bytes

  logic [BYTE_W-1:0] cfg2_q;
  logic              recog_q, m1_q, await2_q, acc_q;
  logic              m1, m2, acc_now, byte2_now, shift, eof_held, tail_wr;
  slot_t             in_slot, tail;

  hafp_addr_cmp #(.CMP_BITS(A1_BITS), .BCAST_EN(1'b0)) u_cmp1 (
    .byte_i (in_byte_i),
    .cfg_i  (addr1_cfg_i),
    .match_o(m1)
  );

  hafp_addr_cmp #(.CMP_BITS(A2_BITS), .BCAST_EN(1'b1)) u_cmp2 (
    .byte_i (in_byte_i),
    .cfg_i  (cfg2_q),
    .match_o(m2)
  );

  assign byte2_now = in_valid_i & await2_q;
  assign acc_now   = ~recog_q | (m1_q & m2);
  assign shift     = in_valid_i | eof_held;

  always_comb begin
    in_slot      = '0;
    in_slot.vld  = in_valid_i;
    in_slot.sof  = in_sof_i;
    in_slot.eof  = in_eof_i;
    in_slot.data = in_byte_i;
    in_slot.drop = in_sof_i & in_eof_i & recog_en_i & (addr1_cfg_i[0] | addr2_cfg_i[0]);
  end

  hafp_hold_line #(.DEPTH(HOLD)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_i   (shift),
    .slot_i    (in_slot),
    .tail_o    (tail),
    .eof_held_o(eof_held)
  );

  // Frame context, captured on the start byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg2_q   <= '0;
      recog_q  <= 1'b0;
      m1_q     <= 1'b1;
      await2_q <= 1'b0;
      acc_q    <= 1'b1;
    end else if (in_valid_i) begin
      if (in_sof_i) begin
        cfg2_q   <= addr2_cfg_i;
        recog_q  <= recog_en_i;
        m1_q     <= m1;
        await2_q <= ~in_eof_i;
      end else begin
        await2_q <= 1'b0;
      end
      if (byte2_now) acc_q <= acc_now;
    end
  end

  // A leaving first byte may meet its own decision in the same cycle
  always_comb begin
    if (tail.sof && tail.eof)      tail_wr = ~tail.drop;
    else if (byte2_now && tail.sof) tail_wr = acc_now;
    else                            tail_wr = acc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_byte_o  <= '0;
      out_sof_o   <= 1'b0;
      out_eof_o   <= 1'b0;
      wr_en_o     <= 1'b0;
    end else begin
      out_valid_o <= shift & tail.vld;
      out_byte_o  <= tail.data;
      out_sof_o   <= shift & tail.vld & tail.sof;
      out_eof_o   <= shift & tail.vld & tail.eof;
      wr_en_o     <= shift & tail.vld & tail_wr;
    end
  end
endmodule

// File: rtl/hafp_checker.sv
module hafp_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic in_valid_i,
  input logic recog_en_i,
  input logic out_valid_o,
  input logic out_sof_o,
  input logic out_eof_o,
  input logic wr_en_o
);
  logic [3:0] occ_q;
  logic       last_wr_q, off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q     <= '0;
      last_wr_q <= 1'b0;
      off_q     <= 1'b1;
    end else begin
      occ_q <= occ_q + {3'b0, in_valid_i} - {3'b0, out_valid_o};
      if (out_valid_o) last_wr_q <= wr_en_o;
      if (recog_en_i)  off_q <= 1'b0;
    end
  end

  assert_wr_only_on_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> out_valid_o);

  assert_marks_on_valid_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_sof_o | out_eof_o) |-> out_valid_o);

  // held bytes plus the output register
  assert_hold_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= 4'd3);

  assert_frame_uniform_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_sof_o) |-> (wr_en_o == last_wr_q));

  assert_off_accepts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && off_q) |-> wr_en_o);
endmodule

bind hdlc_addr_filter hafp_checker u_hafp_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .recog_en_i (recog_en_i),
  .out_valid_o(out_valid_o),
  .out_sof_o  (out_sof_o),
  .out_eof_o  (out_eof_o),
  .wr_en_o    (wr_en_o)
);

// File: tb/hdlc_addr_filter_bench.sv
module hdlc_addr_filter_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid_i = 1'b0;
  logic [7:0] in_byte_i = '0;
  logic       in_sof_i = 1'b0;
  logic       in_eof_i = 1'b0;
  logic       recog_en_i = 1'b0;
  logic [7:0] addr1_cfg_i = '0;
  logic [7:0] addr2_cfg_i = '0;
  logic       out_valid_o, out_sof_o, out_eof_o, wr_en_o;
  logic [7:0] out_byte_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] cap_byte [64];
  logic       cap_sof  [64];
  logic       cap_eof  [64];
  logic       cap_wr   [64];
  int         cap_n = 0;

  always #4 clk_i = ~clk_i;

  hdlc_addr_filter u_hdlc_addr_filter (.*);

  // {recog, cfg1, cfg2, byte1, byte2, expected accept}
  localparam int NV = 13;
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 8'hA1, 8'h00, 8'hA0, 8'h33, 1'b1},  // R2 match
    {1'b1, 8'hA1, 8'h00, 8'hA2, 8'h33, 1'b1},  // R2 bit 1 ignored
    {1'b1, 8'hA1, 8'h00, 8'hA4, 8'h33, 1'b0},  // R2 bit 2 differs
    {1'b1, 8'hA0, 8'h00, 8'hFF, 8'h00, 1'b1},  // R6 both enables off
    {1'b1, 8'hFC, 8'h55, 8'h00, 8'h54, 1'b1},  // R3 / R4 match
    {1'b1, 8'hFC, 8'h55, 8'h13, 8'h55, 1'b1},  // R4 bit 0 ignored
    {1'b1, 8'hFC, 8'h55, 8'h00, 8'h56, 1'b0},  // R4 bit 1 differs
    {1'b1, 8'hFC, 8'h55, 8'h00, 8'hFE, 1'b1},  // R5 broadcast
    {1'b1, 8'hFC, 8'h55, 8'h00, 8'hFF, 1'b1},  // R5 broadcast
    {1'b0, 8'hA1, 8'h55, 8'h00, 8'h00, 1'b1},  // R6 recognition off
    {1'b1, 8'hA1, 8'h55, 8'hA0, 8'h54, 1'b1},  // R7 both match
    {1'b1, 8'hA1, 8'h55, 8'hA0, 8'h00, 1'b0},  // R7 byte 2 fails
    {1'b1, 8'hA1, 8'h55, 8'h00, 8'h54, 1'b0}   // R7 byte 1 fails
  };

  always @(negedge clk_i) begin
    if (out_valid_o && cap_n < 64) begin
      cap_byte[cap_n] = out_byte_o;
      cap_sof[cap_n]  = out_sof_o;
      cap_eof[cap_n]  = out_eof_o;
      cap_wr[cap_n]   = wr_en_o;
      cap_n = cap_n + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic beat(input logic [7:0] b, input logic s, input logic e);
    @(negedge clk_i);
    in_valid_i = 1'b1; in_byte_i = b; in_sof_i = s; in_eof_i = e;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk_i);
      in_valid_i = 1'b0; in_sof_i = 1'b0; in_eof_i = 1'b0;
    end
  endtask

  task automatic check_frame(input string req, input int base, input logic [7:0] b0,
                             input logic [7:0] b1, input logic [7:0] b2, input logic acc);
    check({req, " byte0"}, cap_byte[base],   b0);
    check({req, " byte1"}, cap_byte[base+1], b1);
    check({req, " byte2"}, cap_byte[base+2], b2);
    check({req, " R1 marks"}, {cap_sof[base], cap_eof[base], cap_sof[base+2], cap_eof[base+2]}, 4'b1001);
    for (int k = 0; k < 3; k++) check({req, " wr"}, cap_wr[base+k], acc);
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R11 out_valid in reset", out_valid_o, 0);
    check("R11 wr_en in reset", wr_en_o, 0);
    rst_ni = 1'b1;
    idle(2);

    for (int v = 0; v < NV; v++) begin
      recog_en_i  = VEC[v][33];
      addr1_cfg_i = VEC[v][32:25];
      addr2_cfg_i = VEC[v][24:17];
      cap_n = 0;
      beat(VEC[v][16:9], 1'b1, 1'b0);
      beat(VEC[v][8:1], 1'b0, 1'b0);
      beat(8'h5A, 1'b0, 1'b1);
      idle(6);
      check($sformatf("R1 count vec%0d", v), cap_n, 3);
      check_frame($sformatf("R7 vec%0d", v), 0, VEC[v][16:9], VEC[v][8:1], 8'h5A, VEC[v][0]);
    end

    // R8 single-byte frames
    recog_en_i = 1'b1; addr1_cfg_i = 8'hA1; addr2_cfg_i = 8'h00;
    cap_n = 0;
    beat(8'hA0, 1'b1, 1'b1);
    idle(6);
    check("R8 short count", cap_n, 1);
    check("R8 short dropped", cap_wr[0], 0);
    check("R8 short marks", {cap_sof[0], cap_eof[0]}, 2'b11);
    recog_en_i = 1'b0;
    cap_n = 0;
    beat(8'h00, 1'b1, 1'b1);
    idle(6);
    check("R8 short kept when off", cap_wr[0], 1);

    // R9 mid-frame configuration change
    recog_en_i = 1'b1; addr1_cfg_i = 8'hFC; addr2_cfg_i = 8'h55;
    cap_n = 0;
    beat(8'h00, 1'b1, 1'b0);
    @(posedge clk_i); #1;
    addr2_cfg_i = 8'h00; recog_en_i = 1'b0;
    beat(8'h00, 1'b0, 1'b0);
    beat(8'h11, 1'b0, 1'b1);
    idle(6);
    check("R9 count", cap_n, 3);
    check_frame("R9", 0, 8'h00, 8'h00, 8'h11, 1'b0);

    // R10 hold during mid-frame gaps, then drain
    recog_en_i = 1'b0;
    cap_n = 0;
    beat(8'hA0, 1'b1, 1'b0);
    idle(5);
    #1;
    check("R10 held after byte 1", cap_n, 0);
    beat(8'h33, 1'b0, 1'b0);
    idle(4);
    #1;
    check("R10 held after byte 2", cap_n, 0);
    beat(8'h44, 1'b0, 1'b1);
    idle(2);
    #1;
    check("R10 drain step 2", cap_n, 2);
    idle(1);
    #1;
    check("R10 drain step 3", cap_n, 3);
    idle(3);
    check_frame("R10", 0, 8'hA0, 8'h33, 8'h44, 1'b1);

    // R7 back-to-back frames with differing verdicts, then R8 short
    recog_en_i = 1'b1; addr1_cfg_i = 8'hA1; addr2_cfg_i = 8'h00;
    cap_n = 0;
    beat(8'hA0, 1'b1, 1'b0); beat(8'h11, 1'b0, 1'b0); beat(8'h22, 1'b0, 1'b1);
    beat(8'h00, 1'b1, 1'b0); beat(8'h11, 1'b0, 1'b0); beat(8'h22, 1'b0, 1'b1);
    beat(8'hA0, 1'b1, 1'b1);
    idle(6);
    check("R1 b2b count", cap_n, 7);
    check_frame("R7 b2b first", 0, 8'hA0, 8'h11, 8'h22, 1'b1);
    check_frame("R7 b2b second", 3, 8'h00, 8'h11, 8'h22, 1'b0);
    check("R8 b2b short", cap_wr[6], 0);
    check("R1 b2b short byte", cap_byte[6], 8'hA0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule